// File: doc/BRIEF.md
# Handset Power Sequencing Controller

This block is the digital sequencer that decides which supply regulators of a battery-powered handset are enabled. All of its inputs arrive already digitized: a bank of three battery comparators (below 2.5 V, below 3.0 V, below 3.2 V), a die over-temperature flag, an active-low power button, a keep-alive level from the host processor, a clock-request level from the host, and a charger-present flag. It enables the main digital rails (core, IO, memory) together, the analog and oscillator rails on host request, and the always-on real-time-clock rail. It also drives an active-low system reset whose release is delayed by a counter.

Any one of three wake sources may power the handset up: a debounced button press, the host keep-alive, or a connected charger. The battery gate has hysteresis. Start-up needs the battery above 3.2 V. After that, the rails stay up until the battery drops below 3.0 V. A thermal trip latches the rails off until a fresh wake request arrives. A deep-discharge condition removes every rail, the clock rail included. Every asynchronous input passes through a two-flop synchronizer before the state machine uses it.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rstN` is low, `coreEn`, `ioEn`, `memEn`, `anaEn`, `oscEn` and `sysRstN` are low and `rtcEn` is high.
- R2: With the battery qualified and no thermal latch, holding `keyN` low powers the main rails. The first rail enable appears exactly DEB_CYCLES+3 clock edges after `keyN` falls. The three main enables always switch together. Releasing the button while `hostHold` and `chgDet` are low turns the main rails off.
- R3: A low pulse on `keyN` shorter than DEB_CYCLES cycles never enables a rail.
- R4: `hostHold` high or `chgDet` high each power the main rails on their own and keep them on.
- R5: `anaEn` and `oscEn` equal `clkReq` while the main rails are on, and are low while the main rails are off.
- R6: Start-up needs all three battery comparators clear, meaning the battery is above 3.2 V. Once qualified, the rails stay on while `battBelow32` is high but `battBelow30` is low. When `battBelow30` rises, the rails turn off and stay off until the battery is above 3.2 V again. A charger does not start the rails while the battery is unqualified. The rails are off by the fourth clock edge after `battBelow30` is sampled high.
- R7: `battBelow25` high turns every enable off, `rtcEn` included, by the third edge. Otherwise `rtcEn` is high.
- R8: `overTemp` high turns all rail enables except `rtcEn` off by the third edge. The rails then stay off after the flag clears, until one of the wake sources goes from inactive to active.
- R9: `sysRstN` is low in the cycle the main rails come on. It rises exactly RST_DLY cycles later. It is low whenever the main rails are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| keyN | input | 1 | Power button, low while pressed (asynchronous) |
| hostHold | input | 1 | Host keep-alive level (asynchronous) |
| chgDet | input | 1 | Charger present flag (asynchronous) |
| clkReq | input | 1 | Host request for analog and oscillator rails (asynchronous) |
| overTemp | input | 1 | Die over-temperature flag (asynchronous) |
| battBelow25 | input | 1 | Battery below 2.5 V comparator |
| battBelow30 | input | 1 | Battery below 3.0 V comparator |
| battBelow32 | input | 1 | Battery below 3.2 V comparator |
| coreEn | output | 1 | Core regulator enable |
| ioEn | output | 1 | IO regulator enable |
| memEn | output | 1 | Memory regulator enable |
| anaEn | output | 1 | Analog regulator enable |
| oscEn | output | 1 | Oscillator regulator enable |
| rtcEn | output | 1 | Real-time-clock regulator enable |
| sysRstN | output | 1 | Active-low system reset |

## Verification
Each input first crosses the two synchronizer flops. Level inputs then act on the state register at the third edge. A button press needs DEB_CYCLES further edges, so the rails appear DEB_CYCLES+3 edges after `keyN` falls. Reset release follows the rails by exactly RST_DLY edges. The battery lockout takes one more edge than the other inputs because of the qualification register.

Two directed checks count falling edges from the stimulus and compare the count with these figures: button press to rails, and rails to reset release. Every other check changes one input at a time and then waits a settle window longer than DEB_CYCLES+RST_DLY before sampling. The expected value therefore never depends on a transient.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int SYNC_DEPTH = 2;
  localparam int NUM_ASYNC  = 8;

  // battery comparator bits reset to "low battery" so nothing starts early
  localparam logic [NUM_ASYNC-1:0] SYNC_RST_VAL = 8'b0000_0111;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_DELAY,
    ST_RUN,
    ST_THERM,
    ST_DEAD
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntRun;
  } dlyStrobe_t;

  typedef struct packed {
    logic keyDown;
    logic hostHold;
    logic chgDet;
    logic clkReq;
    logic overTemp;
    logic below25;
    logic below30;
    logic below32;
  } condIn_t;

endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int RST_DLY    = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_ASYNC-1:0] rawIn,
  input  dlyStrobe_t           strobe,
  output condIn_t              cond,
  output logic                 dlyDone
);

  localparam int DEB_W = $clog2(DEB_CYCLES + 1);
  localparam int DLY_W = $clog2(RST_DLY + 1);

  logic [NUM_ASYNC-1:0] syncStage [SYNC_DEPTH];

  genvar s;
  generate
    for (s = 0; s < SYNC_DEPTH; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncStage[s] <= SYNC_RST_VAL;
        else if (s == 0) syncStage[s] <= rawIn;
        else             syncStage[s] <= syncStage[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  condIn_t syncCond;
  assign syncCond = syncStage[SYNC_DEPTH-1];

  // button debounce: the stable level follows only after DEB_CYCLES agreeing samples
  logic             keyStable;
  logic [DEB_W-1:0] debCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyStable <= 1'b0;
      debCnt    <= '0;
    end else if (syncCond.keyDown == keyStable) begin
      debCnt <= '0;
    end else if (debCnt == DEB_W'(DEB_CYCLES - 1)) begin
      keyStable <= syncCond.keyDown;
      debCnt    <= '0;
    end else begin
      debCnt <= debCnt + DEB_W'(1);
    end
  end

  always_comb begin
    cond         = syncCond;
    cond.keyDown = keyStable;
  end

  // reset release timer
  logic [DLY_W-1:0] dlyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dlyCnt <= '0;
    else if (strobe.cntClr) dlyCnt <= '0;
    else if (strobe.cntRun) dlyCnt <= dlyCnt + DLY_W'(1);
  end

  assign dlyDone = (dlyCnt == DLY_W'(RST_DLY - 1));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  condIn_t    cond,
  input  logic       dlyDone,
  output dlyStrobe_t strobe,
  output logic       mainOn,
  output logic       auxOn,
  output logic       rtcOn,
  output logic       rstRelease
);

  seqState_t state, stateNext;
  logic      battOk;
  logic      wakePrev;
  logic      wake;
  logic      wakeRise;

  assign wake     = cond.keyDown | cond.hostHold | cond.chgDet;
  assign wakeRise = wake & ~wakePrev;

  // battery qualification with hysteresis: set above 3.2 V, cleared below 3.0 V
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             battOk <= 1'b0;
    else if (cond.below30) battOk <= 1'b0;
    else if (!cond.below32) battOk <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      wakePrev <= 1'b0;
    end else begin
      state    <= stateNext;
      wakePrev <= wake;
    end
  end

  always_comb begin
    stateNext = state;
    if (cond.below25) begin
      stateNext = ST_DEAD;
    end else if (cond.overTemp) begin
      stateNext = ST_THERM;
    end else begin
      case (state)
        ST_OFF:   if (battOk && wake) stateNext = ST_DELAY;
        ST_DELAY: begin
          if (!battOk || !wake) stateNext = ST_OFF;
          else if (dlyDone)     stateNext = ST_RUN;
        end
        ST_RUN:   if (!battOk || !wake) stateNext = ST_OFF;
        ST_THERM: if (battOk && wakeRise) stateNext = ST_DELAY;
        ST_DEAD:  stateNext = ST_OFF;
        default:  stateNext = ST_OFF;
      endcase
    end
  end

  always_comb begin
    strobe.cntRun = (state == ST_DELAY);
    strobe.cntClr = (state != ST_DELAY);
  end

  assign mainOn     = (state == ST_DELAY) || (state == ST_RUN);
  assign auxOn      = mainOn && cond.clkReq;
  assign rtcOn      = (state != ST_DEAD);
  assign rstRelease = (state == ST_RUN);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int RST_DLY    = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic keyN,
  input  logic hostHold,
  input  logic chgDet,
  input  logic clkReq,
  input  logic overTemp,
  input  logic battBelow25,
  input  logic battBelow30,
  input  logic battBelow32,
  output logic coreEn,
  output logic ioEn,
  output logic memEn,
  output logic anaEn,
  output logic oscEn,
  output logic rtcEn,
  output logic sysRstN
);

  logic [NUM_ASYNC-1:0] rawIn;
  condIn_t              cond;
  dlyStrobe_t           strobe;
  logic                 dlyDone;
  logic                 mainOn;
  logic                 auxOn;
  logic                 rtcOn;
  logic                 rstRelease;

  assign rawIn = {~keyN, hostHold, chgDet, clkReq, overTemp,
                  battBelow25, battBelow30, battBelow32};

  pwr_seq_dp #(
    .DEB_CYCLES(DEB_CYCLES),
    .RST_DLY   (RST_DLY)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (rawIn),
    .strobe (strobe),
    .cond   (cond),
    .dlyDone(dlyDone)
  );

  pwr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cond      (cond),
    .dlyDone   (dlyDone),
    .strobe    (strobe),
    .mainOn    (mainOn),
    .auxOn     (auxOn),
    .rtcOn     (rtcOn),
    .rstRelease(rstRelease)
  );

  assign coreEn  = mainOn;
  assign ioEn    = mainOn;
  assign memEn   = mainOn;
  assign anaEn   = auxOn;
  assign oscEn   = auxOn;
  assign rtcEn   = rtcOn;
  assign sysRstN = rstRelease;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic rstN,
  input logic overTemp,
  input logic battBelow25,
  input logic battBelow30,
  input logic coreEn,
  input logic ioEn,
  input logic memEn,
  input logic anaEn,
  input logic oscEn,
  input logic rtcEn,
  input logic sysRstN
);

  // cycles since reset, saturating, so $past never reaches into reset
  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  assert_aux_needs_main_R5: assert property (@(posedge clk) disable iff (!rstN)
    (anaEn || oscEn) |-> coreEn);

  assert_reset_low_at_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreEn) |-> !sysRstN);

  assert_reset_needs_rails_R9: assert property (@(posedge clk) disable iff (!rstN)
    sysRstN |-> (coreEn && ioEn && memEn));

  assert_thermal_cut_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd6 && $past(overTemp, 3)) |-> !coreEn);

  assert_deep_discharge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd6 && $past(battBelow25, 3)) |-> (!rtcEn && !coreEn));

  assert_lockout_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd6 && $past(battBelow30, 4)) |-> !coreEn);

endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .overTemp   (overTemp),
  .battBelow25(battBelow25),
  .battBelow30(battBelow30),
  .coreEn     (coreEn),
  .ioEn       (ioEn),
  .memEn      (memEn),
  .anaEn      (anaEn),
  .oscEn      (oscEn),
  .rtcEn      (rtcEn),
  .sysRstN    (sysRstN)
);

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;

  localparam int DEB    = 8;
  localparam int DLY    = 24;
  localparam int SETTLE = DLY + DEB + 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, keyN, hostHold, chgDet, clkReq, overTemp;
  logic battBelow25, battBelow30, battBelow32;
  logic coreEn, ioEn, memEn, anaEn, oscEn, rtcEn, sysRstN;

  pwr_seq_top #(.DEB_CYCLES(DEB), .RST_DLY(DLY)) u0 (
    .clk(clk), .rstN(rstN), .keyN(keyN), .hostHold(hostHold), .chgDet(chgDet),
    .clkReq(clkReq), .overTemp(overTemp), .battBelow25(battBelow25),
    .battBelow30(battBelow30), .battBelow32(battBelow32), .coreEn(coreEn),
    .ioEn(ioEn), .memEn(memEn), .anaEn(anaEn), .oscEn(oscEn), .rtcEn(rtcEn),
    .sysRstN(sysRstN)
  );

  int errors = 0;
  int checks = 0;

  // stimulus state: lvl 0 (<2.5 V), 1 (2.5..3.0), 2 (3.0..3.2), 3 (>3.2)
  int lvl = 3;
  bit ot = 0, key = 0, hold = 0, ck = 0, chg = 0;

  // reference model state
  bit mBattOk = 0, mTherm = 0, mPrevWake = 0, mOn = 0, mDead = 0;

  function automatic logic [6:0] outVec();
    return {coreEn, ioEn, memEn, anaEn, oscEn, rtcEn, sysRstN};
  endfunction

  function automatic logic [6:0] expVec(bit on, bit clkOn, bit dead);
    return {on, on, on, on & clkOn, on & clkOn, !dead, on};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive();
    keyN        = !key;
    hostHold    = hold;
    chgDet      = chg;
    clkReq      = ck;
    overTemp    = ot;
    battBelow25 = (lvl <= 0);
    battBelow30 = (lvl <= 1);
    battBelow32 = (lvl <= 2);
  endtask

  task automatic modelUpdate();
    bit wake;
    wake  = key | hold | chg;
    mDead = (lvl == 0);
    if (lvl <= 1)      mBattOk = 0;
    else if (lvl == 3) mBattOk = 1;
    if (mDead)                                      mTherm = 0;
    else if (ot)                                    mTherm = 1;
    else if (mTherm && wake && !mPrevWake && mBattOk) mTherm = 0;
    mPrevWake = wake;
    mOn = !mDead && !mTherm && mBattOk && wake;
  endtask

  task automatic stepCheck(string req);
    @(negedge clk);
    drive();
    repeat (SETTLE) @(negedge clk);
    modelUpdate();
    check(req, 32'(outVec()), 32'(expVec(mOn, ck, mDead)));
  endtask

  initial begin
    int n;
    int m;
    bit seen;
    void'($urandom(32'd4242));
    rstN = 1'b0;
    drive();
    repeat (3) @(negedge clk);
    check("R1 reset state", 32'(outVec()), 32'(7'b0000010));
    rstN = 1'b1;
    stepCheck("R1 idle after reset");

    // R3: short button glitch
    @(negedge clk);
    key = 1; drive();
    repeat (DEB - 3) @(negedge clk);
    key = 0; drive();
    seen = 0;
    repeat (SETTLE) begin
      @(negedge clk);
      if (coreEn) seen = 1;
    end
    check("R3 glitch ignored", 32'(seen), 32'd0);
    modelUpdate();

    // R2 and R9: exact latencies
    @(negedge clk);
    key = 1; drive();
    n = 0;
    while (!coreEn && n < 200) begin
      @(negedge clk);
      n++;
    end
    check("R2 button to rails latency", 32'(n), 32'(DEB + 3));
    check("R9 reset low as rails rise", 32'(sysRstN), 32'd0);
    m = 0;
    while (!sysRstN && m < 400) begin
      @(negedge clk);
      m++;
    end
    check("R9 reset release delay", 32'(m), 32'(DLY));
    stepCheck("R2 button held");

    ck = 1;   stepCheck("R5 clock request on");
    ck = 0;   stepCheck("R5 clock request off");
    key = 0;  stepCheck("R2 button released");
    hold = 1; stepCheck("R4 keep-alive starts");
    hold = 0; stepCheck("R4 keep-alive dropped");
    chg = 1;  stepCheck("R4 charger starts");
    chg = 0;  stepCheck("R4 charger removed");
    ck = 1;   stepCheck("R5 request with rails off");
    ck = 0;   stepCheck("R5 idle");

    // R6 hysteresis
    hold = 1; stepCheck("R6 qualified start");
    lvl = 2;  stepCheck("R6 stays on above 3.0");
    lvl = 1;  stepCheck("R6 off below 3.0");
    lvl = 2;  stepCheck("R6 no restart below 3.2");
    hold = 0; stepCheck("R6 idle");
    chg = 1;  stepCheck("R6 charger in lockout");
    lvl = 3;  stepCheck("R6 restart above 3.2");
    chg = 0;  stepCheck("R6 idle again");

    // R8 thermal latch
    hold = 1; stepCheck("R8 running");
    ot = 1;   stepCheck("R8 trip");
    ot = 0;   stepCheck("R8 latched after clear");
    hold = 0; stepCheck("R8 wake released");
    hold = 1; stepCheck("R8 fresh wake restarts");

    // R7 deep discharge
    lvl = 2;  stepCheck("R7 level 2");
    lvl = 1;  stepCheck("R7 level 1");
    lvl = 0;  stepCheck("R7 everything off");
    lvl = 1;  stepCheck("R7 rtc back");
    lvl = 2;  stepCheck("R7 still locked");
    lvl = 3;  stepCheck("R7 recovered");
    hold = 0; stepCheck("R7 idle");

    // constrained random, one input changed per step
    for (int i = 0; i < 250; i++) begin
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: begin
          if ($urandom_range(0, 1) == 1) lvl = (lvl < 3) ? lvl + 1 : lvl - 1;
          else                           lvl = (lvl > 0) ? lvl - 1 : lvl + 1;
        end
        1: ot   = ($urandom_range(0, 3) == 0);
        2: key  = !key;
        3: hold = !hold;
        4: ck   = !ck;
        default: chg = !chg;
      endcase
      stepCheck("R4/R5/R6/R7/R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule